// File: doc/BRIEF.md
# Occupancy-Flagged Synchronous FIFO

This block is a single-clock FIFO of power-of-two depth `DEPTH`. It has two occupancy flags that are active low and programmable. The almost-full flag uses a fill offset `m` and the almost-empty flag uses a drain offset `n`. Both offsets reset to parameter defaults. They can be reloaded through a small load port, but only until the first word is accepted after reset.

A static mode input selects the read style:

- **Standard mode.** Each accepted read moves the next word into the output register.
- **Look-ahead mode.** The head word is presented at the output before any read is made. That output register adds one word of capacity, and both flag thresholds move up by one.

A retransmit mode freezes a mark at the current head. While it is active, stored words are protected from being overwritten, and almost-full measures the distance from the write pointer to the mark. A rewind request returns reading to the mark so that the same words can be read again.

An active-low echo output is low during each cycle that follows an accepted read. A free-running echo clock output copies the clock.

Top module: `occ_fifo`

## Requirements
- R1: The reset input `rst` is synchronous and active high. After reset, `empty` is 1, `full` is 0, `almost_empty_n` is 0, `almost_full_n` is 1, `rd_echo_n` is 1 and `rd_data` is 0. The offsets return to `DEF_M` and `DEF_N`.
- R2: This requirement covers standard mode (`fwft_sel`=0). A read is accepted at a clock edge when `rd_en_n`=0, `rd_cs_n`=0 and at least one word is stored. The oldest word then appears on `rd_data` after that edge, and `rd_data` holds its value otherwise.
- R3: This requirement covers look-ahead mode (`fwft_sel`=1). A word written into an empty FIFO appears on `rd_data` after the second edge without any read. `empty` falls after that same edge. An accepted read consumes the word on the output, and the next word replaces it after the same edge.
- R4: This requirement covers full and empty behaviour. `full` is 1 when the storage array holds `DEPTH` words. The total capacity is `DEPTH` words in standard mode and `DEPTH+1` in look-ahead mode. A write while `full` is 1 is ignored. A read while `empty` is 1 is ignored: `rd_data` does not change and `rd_echo_n` stays high.
- R5: In standard mode, `almost_full_n` is 0 exactly when the stored word count is at least `DEPTH - m`.
- R6: In look-ahead mode, `almost_full_n` is 0 exactly when the stored word count, including the output word, is at least `DEPTH + 1 - m`.
- R7: `almost_empty_n` is 0 exactly when the stored word count is at most `n` in standard mode, or at most `n + 1` in look-ahead mode.
- R8: A pulse on `off_ld_full` copies `off_val` into `m`, and a pulse on `off_ld_empty` copies it into `n`. The new value takes effect after that edge. A load is accepted only if no write has been accepted on any earlier edge since reset; otherwise it is ignored.
- R9: `rd_echo_n` is 0 for exactly the cycle after each edge that accepts a read, and 1 in every other cycle. This includes cycles where `rd_cs_n` is 1.
- R10: The edge at which `rt_mode` is first seen high freezes a mark at the head of the FIFO. While the mark is held, almost-full compares the write-to-mark distance against `DEPTH - m` in both read modes. `full` is 1 when that distance equals `DEPTH`. When `rt_mode` falls, normal counting resumes after the next edge.
- R11: While the mark is held, an edge with `rt_go`=1 moves reading back to the mark, and no read is accepted on that edge. The words from the mark onward are then read again in their original order.
- R12: `echo_clk` follows `clk` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| fwft_sel | input | 1 | 1 selects look-ahead read mode; change it only while in reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| rd_en_n | input | 1 | Read request, active low |
| rd_cs_n | input | 1 | Read chip select, active low |
| rt_mode | input | 1 | Holds the retransmit mark while high |
| rt_go | input | 1 | Rewind reading to the mark |
| off_ld_full | input | 1 | Load `off_val` into the almost-full offset |
| off_ld_empty | input | 1 | Load `off_val` into the almost-empty offset |
| off_val | input | AW+1 | Offset value |
| rd_data | output | DW | Output word register |
| empty | output | 1 | No readable word |
| full | output | 1 | No space for a write |
| almost_full_n | output | 1 | Programmable almost-full flag, active low |
| almost_empty_n | output | 1 | Programmable almost-empty flag, active low |
| rd_echo_n | output | 1 | Low for the cycle after an accepted read |
| echo_clk | output | 1 | Free-running copy of the clock |

## Verification
The bench builds the block with `DEPTH`=8 and `DW`=8, and with both default offsets set to 2. At that depth every fill level from empty to overfull is visited, in both read modes. The runs use four offset pairs, including zero offsets and offsets larger than half the depth, so every flag edge is reached within a few dozen cycles. A scripted retransmit run fills the storage array past the point where plain counting and mark-relative counting disagree. That run then wraps the write pointer onto freed slots and replays all eight words after the rewind.

// File: rtl/occ_fifo_pkg.sv
package occ_fifo_pkg;

    typedef enum logic {
        RD_STD  = 1'b0,
        RD_LOOK = 1'b1
    } rd_mode_e;

    function automatic logic lvl_at_least(int lvl, int thr);
        return lvl >= thr;
    endfunction

    function automatic logic lvl_at_most(int lvl, int thr);
        return lvl <= thr;
    endfunction

endpackage

// File: rtl/occ_fifo_mem.sv
module occ_fifo_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= cells[raddr];
    end
endmodule

// File: rtl/occ_fifo_ptrs.sv
module occ_fifo_ptrs
    import occ_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_mode_e      mode,
    input  logic          wr_en,
    input  logic          rd_en_n,
    input  logic          rd_cs_n,
    input  logic          rt_mode,
    input  logic          rt_go,
    output logic          wr_ok,
    output logic [AW-1:0] waddr,
    output logic          fetch,
    output logic [AW-1:0] raddr,
    output logic          empty,
    output logic          full,
    output logic          rd_echo_n,
    output logic          rt_act,
    output logic [PW:0]   fill_lvl,
    output logic [PW-1:0] mark_lvl
);
    logic [PW-1:0] wr_ptr, rd_ptr, mark_ptr, head, mem_cnt, keep_cnt;
    logic          out_v, look, rewind, rd_req, have, rd_ok;

    assign look     = (mode == RD_LOOK);
    assign mem_cnt  = wr_ptr - rd_ptr;
    assign head     = rd_ptr - PW'(out_v);
    assign mark_lvl = wr_ptr - mark_ptr;
    assign keep_cnt = rt_act ? mark_lvl : mem_cnt;
    assign full     = (keep_cnt == PW'(DEPTH));
    assign wr_ok    = wr_en && !full;
    assign rewind   = rt_go && rt_act;
    assign rd_req   = !rd_en_n && !rd_cs_n && !rewind;
    assign have     = look ? out_v : (mem_cnt != '0);
    assign rd_ok    = rd_req && have;
    assign fetch    = !rewind && (mem_cnt != '0) && (look ? (!out_v || rd_ok) : rd_ok);
    assign empty    = !have;
    assign waddr    = wr_ptr[AW-1:0];
    assign raddr    = rd_ptr[AW-1:0];
    assign fill_lvl = {1'b0, mem_cnt} + (PW+1)'(out_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            mark_ptr  <= '0;
            out_v     <= 1'b0;
            rt_act    <= 1'b0;
            rd_echo_n <= 1'b1;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + PW'(1);
            if (rewind) begin
                rd_ptr <= mark_ptr;
                out_v  <= 1'b0;
            end else begin
                if (fetch) rd_ptr <= rd_ptr + PW'(1);
                if (look && fetch)      out_v <= 1'b1;
                else if (look && rd_ok) out_v <= 1'b0;
            end
            if (rt_mode && !rt_act) mark_ptr <= head;
            rt_act    <= rt_mode;
            rd_echo_n <= !rd_ok;
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        mem_cnt <= PW'(DEPTH));
    a_r4_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(wr_ptr));
    a_r4_empty_no_pop: assert property (@(posedge clk) disable iff (rst)
        (mem_cnt == '0 && !rewind) |=> $stable(rd_ptr));
    a_r9_echo_needs_request: assert property (@(posedge clk) disable iff (rst)
        !rd_echo_n |-> $past(!rd_en_n && !rd_cs_n));
    a_r10_mark_frozen: assert property (@(posedge clk) disable iff (rst)
        rt_act |=> $stable(mark_ptr));
endmodule

// File: rtl/occ_fifo_flags.sv
module occ_fifo_flags
    import occ_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int OW    = AW + 1,
    parameter int PW    = AW + 1,
    parameter int DEF_M = 2,
    parameter int DEF_N = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_mode_e      mode,
    input  logic          rt_act,
    input  logic          wr_ok,
    input  logic          off_ld_full,
    input  logic          off_ld_empty,
    input  logic [OW-1:0] off_val,
    input  logic [PW:0]   fill_lvl,
    input  logic [PW-1:0] mark_lvl,
    output logic          almost_full_n,
    output logic          almost_empty_n
);
    logic [OW-1:0] m_off, n_off;
    logic          touched;
    int            af_thr, af_lvl, ae_thr;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_off   <= OW'(DEF_M);
            n_off   <= OW'(DEF_N);
            touched <= 1'b0;
        end else begin
            if (wr_ok) touched <= 1'b1;
            if (!touched && off_ld_full)  m_off <= off_val;
            if (!touched && off_ld_empty) n_off <= off_val;
        end
    end

    always_comb begin
        af_thr = DEPTH + (((mode == RD_LOOK) && !rt_act) ? 1 : 0) - int'(m_off);
        af_lvl = rt_act ? int'(mark_lvl) : int'(fill_lvl);
        ae_thr = int'(n_off) + ((mode == RD_LOOK) ? 1 : 0);
        almost_full_n  = !lvl_at_least(af_lvl, af_thr);
        almost_empty_n = !lvl_at_most(int'(fill_lvl), ae_thr);
    end

    a_r8_offsets_locked: assert property (@(posedge clk) disable iff (rst)
        touched |=> ($stable(m_off) && $stable(n_off)));
endmodule

// File: rtl/occ_fifo.sv
module occ_fifo
    import occ_fifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int DEF_M = 2,
    parameter int DEF_N = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int OW   = AW + 1,
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en_n,
    input  logic          rd_cs_n,
    input  logic          rt_mode,
    input  logic          rt_go,
    input  logic          off_ld_full,
    input  logic          off_ld_empty,
    input  logic [OW-1:0] off_val,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full,
    output logic          almost_full_n,
    output logic          almost_empty_n,
    output logic          rd_echo_n,
    output logic          echo_clk
);
    rd_mode_e      mode;
    logic          wr_ok, fetch, rt_act;
    logic [AW-1:0] waddr, raddr;
    logic [PW:0]   fill_lvl;
    logic [PW-1:0] mark_lvl;

    assign mode     = rd_mode_e'(fwft_sel);
    assign echo_clk = clk;

    occ_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ptrs (
        .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en),
        .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rt_mode(rt_mode), .rt_go(rt_go),
        .wr_ok(wr_ok), .waddr(waddr), .fetch(fetch), .raddr(raddr),
        .empty(empty), .full(full), .rd_echo_n(rd_echo_n), .rt_act(rt_act),
        .fill_lvl(fill_lvl), .mark_lvl(mark_lvl)
    );

    occ_fifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst(rst), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
        .re(fetch), .raddr(raddr), .rdata(rd_data)
    );

    occ_fifo_flags #(.DEPTH(DEPTH), .AW(AW), .OW(OW), .PW(PW),
                     .DEF_M(DEF_M), .DEF_N(DEF_N)) u_flags (
        .clk(clk), .rst(rst), .mode(mode), .rt_act(rt_act), .wr_ok(wr_ok),
        .off_ld_full(off_ld_full), .off_ld_empty(off_ld_empty), .off_val(off_val),
        .fill_lvl(fill_lvl), .mark_lvl(mark_lvl),
        .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
    );

    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty && !full && !almost_empty_n && rd_echo_n));
endmodule

// File: tb/occ_fifo_bench.sv
module occ_fifo_bench;
    localparam int D  = 8;
    localparam int DW = 8;
    localparam int DM = 2;
    localparam int DN = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1, fwft_sel = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1, rd_cs_n = 1'b1, rt_mode = 1'b0, rt_go = 1'b0;
    logic          off_ld_full = 1'b0, off_ld_empty = 1'b0;
    logic [3:0]    off_val = '0;
    logic [DW-1:0] rd_data;
    logic          empty, full, almost_full_n, almost_empty_n, rd_echo_n, echo_clk;

    occ_fifo #(.DW(DW), .DEPTH(D), .DEF_M(DM), .DEF_N(DN)) u_occ_fifo (
        .clk(clk), .rst(rst), .fwft_sel(fwft_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rt_mode(rt_mode), .rt_go(rt_go),
        .off_ld_full(off_ld_full), .off_ld_empty(off_ld_empty), .off_val(off_val),
        .rd_data(rd_data), .empty(empty), .full(full), .almost_full_n(almost_full_n),
        .almost_empty_n(almost_empty_n), .rd_echo_n(rd_echo_n), .echo_clk(echo_clk)
    );

    int tests = 0, fails = 0;
    logic [DW-1:0] mq[$];
    bit  ov, fw, touched;
    logic [DW-1:0] ow, sd, wcnt = 8'd1;
    int  mm, nn;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; rd_en_n = 1; rd_cs_n = 1; rt_go = 0;
        off_ld_full = 0; off_ld_empty = 0;
    endtask

    task automatic do_reset(bit f);
        idle_inputs();
        rt_mode = 0; fw = f; fwft_sel = f; rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        mq.delete(); ov = 0; sd = '0; mm = DM; nn = DN; touched = 0;
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 almost_empty_n", almost_empty_n, 0);
        chk("R1 almost_full_n", almost_full_n, 1);
        chk("R1 rd_echo_n", rd_echo_n, 1);
        chk("R1 rd_data", rd_data, 0);
    endtask

    // One modelled clock: inputs driven at the falling edge, outputs checked at the next one.
    task automatic step(bit we, bit re, bit cs, bit ldf, bit lde, int val);
        int sz, lvl;
        bit wok, rok, fetch;
        logic [DW-1:0] w;
        wr_en = we; wr_data = wcnt; rd_en_n = !re; rd_cs_n = !cs;
        off_ld_full = ldf; off_ld_empty = lde; off_val = 4'(val);
        sz  = mq.size();
        wok = we && (sz != D);
        rok = re && cs && (fw ? ov : (sz > 0));
        if (!touched) begin           // R8: loads before the first accepted write
            if (ldf) mm = val;
            if (lde) nn = val;
        end
        if (wok) touched = 1;
        fetch = (sz > 0) && (fw ? (!ov || rok) : rok);
        if (fetch) begin
            w = mq.pop_front();
            if (fw) begin ow = w; ov = 1; end
            else sd = w;
        end else if (fw && rok) ov = 0;
        if (wok) begin mq.push_back(wcnt); wcnt++; end
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        lvl = mq.size() + int'(ov);
        chk(fw ? "R3 empty" : "R4 empty", empty, fw ? int'(!ov) : int'(mq.size() == 0));
        chk("R4 full", full, int'(mq.size() == D));
        chk(fw ? "R6 almost_full_n" : "R5 almost_full_n", almost_full_n,
            int'(!(lvl >= D + int'(fw) - mm)));
        chk("R7 almost_empty_n", almost_empty_n, int'(!(lvl <= nn + int'(fw))));
        chk("R9 rd_echo_n", rd_echo_n, int'(!rok));
        if (fw && ov) chk("R3 rd_data", rd_data, ow);
        if (!fw)      chk("R2 rd_data", rd_data, sd);
    endtask

    task automatic raw(bit we, logic [DW-1:0] d, bit re, bit go);
        wr_en = we; wr_data = d; rd_en_n = !re; rd_cs_n = !re; rt_go = go;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #1_500_000;
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int mv[4] = '{DM, 0, 3, 5};
        int nv[4] = '{DN, 0, 4, 1};
        @(negedge clk);
        for (int md = 0; md < 2; md++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                do_reset(md[0]);
                if (cfg > 0) begin
                    step(0, 0, 0, 1, 0, mv[cfg]);
                    step(0, 0, 0, 0, 1, nv[cfg]);
                end
                for (int i = 0; i < D + 3; i++) step(1, 0, 0, 0, 0, 0);
                step(0, 0, 0, 1, 1, 1);              // R8: late load must be ignored
                step(0, 1, 0, 0, 0, 0);              // R9: chip select off, no read
                for (int i = 0; i < D + 4; i++) step(0, 1, 1, 0, 0, 0);
                for (int i = 0; i < 40; i++) step(i % 3 != 2, i % 2 == 0, i % 5 != 4, 0, 0, 0);
                for (int i = 0; i < D + 4; i++) step(0, 1, 1, 0, 0, 0);
            end
        end

        // R12: echo clock tracks the clock
        chk("R12 echo_clk low", echo_clk, 0);
        @(posedge clk); #1;
        chk("R12 echo_clk high", echo_clk, 1);
        @(negedge clk);

        // R10 / R11: retransmit in standard mode, default offsets
        do_reset(0);
        for (int k = 0; k < 5; k++) raw(1, 8'(10 + k), 0, 0);
        raw(0, 0, 1, 0);
        chk("R2 first read", rd_data, 10);
        rt_mode = 1;
        raw(0, 0, 0, 0);
        raw(0, 0, 1, 0);
        chk("R10 read in mark mode", rd_data, 11);
        raw(0, 0, 1, 0);
        chk("R10 read in mark mode", rd_data, 12);
        raw(1, 8'd15, 0, 0);
        chk("R10 almost_full_n below", almost_full_n, 1);
        raw(1, 8'd16, 0, 0);
        chk("R10 almost_full_n from mark", almost_full_n, 0);
        raw(1, 8'd17, 0, 0);
        raw(1, 8'd18, 0, 0);
        chk("R10 full at mark distance", full, 1);
        raw(1, 8'd19, 0, 0);
        raw(0, 0, 1, 1);
        chk("R11 rewind echo", rd_echo_n, 1);
        chk("R10 full after rewind", full, 1);
        chk("R11 not empty", empty, 0);
        for (int k = 0; k < 8; k++) begin
            raw(0, 0, 1, 0);
            chk("R11 replay", rd_data, 11 + k);
        end
        chk("R11 drained", empty, 1);
        rt_mode = 0;
        raw(0, 0, 0, 0);
        chk("R10 full released", full, 0);
        chk("R10 almost_full_n released", almost_full_n, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule